// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory instruction at a time against a synchronous memory port. A request supplies the 8-bit opcode, the 32-bit immediate, the signed 16-bit offset, the base register value, the source register value and the current R0. The unit decodes the operation, adds the offset to the base to form the address, and issues a locked read. In the next cycle it computes the update and, when the operation calls for one, issues the write. It then pulses a completion strobe with the value to be written back and the register that receives it.

The request side uses valid/ready. `req_ready` is high only while the unit is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. The unit captures every request field at that edge, so the requester may change them freely afterwards. Until the completion pulse, the requester must wait, because `req_ready` stays low. The memory port has no back-pressure. Read data must appear on `mem_rdata` in the cycle after the read request. `lock` tells any arbiter to keep other requesters away from the memory.

Top module: `atom_rmw_unit`

## Requirements
- R1: Out of reset `req_ready` is 1 and `lock`, `mem_req` and `done` are 0.
- R2: A supported request produces `done` exactly three cycles after the accepting edge. An unsupported request produces `done` exactly one cycle after it. `req_ready` is low from the accepting edge until `done`.
- R3: Opcode 0xc3 selects a 32-bit operation (`mem_wide`=0) and 0xdb selects a 64-bit operation (`mem_wide`=1). Any other opcode completes with `err`=1, `wb_tgt`=0 and no memory request.
- R4: Supported immediates are 0x00 add, 0x40 OR, 0x50 AND and 0xa0 XOR, each of which may also have bit 0 set (fetch). 0xe1 is exchange and 0xf1 is compare-exchange. Any other immediate completes with `err`=1, `wb_tgt`=0 and no memory request.
- R5: The memory address is the low ADDR_W bits of the base value plus the sign-extended 16-bit offset.
- R6: Add, OR, AND and XOR write to memory the old value combined with the source value. Add wraps. A 32-bit operation uses only the low 32 bits of the source and of the old value.
- R7: With the fetch bit set, `wb_tgt`=1 (source register) and `wb_data` is the old memory value, zero-extended for 32-bit operations. Without it, `wb_tgt`=0 and `wb_data`=0.
- R8: Exchange writes the source value to memory and returns the old value with `wb_tgt`=1.
- R9: Compare-exchange compares the old value with R0, using the low 32 bits only for 32-bit operations. It writes the source value only on a match. It always returns the zero-extended old value with `wb_tgt`=2 (R0). On a mismatch it issues no write.
- R10: `lock` is high for exactly the read cycle and the cycle after it. Every memory request occurs while `lock` is high. A write is issued only in the cycle directly after a read, and to the same address.
- R11: `done` is a one-cycle pulse, and a successful request makes exactly one read and at most one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_opcode | input | 8 | Instruction opcode |
| req_imm | input | 32 | Immediate selecting the operation |
| req_offset | input | 16 | Signed address offset |
| req_dst | input | 64 | Base register value |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Current R0 value |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = low 32 bits |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after the read request |
| lock | output | 1 | Memory held for the update |
| done | output | 1 | Completion pulse |
| err | output | 1 | Request was unsupported (valid with done) |
| wb_tgt | output | 2 | Write-back target: 0 none, 1 source, 2 R0 |
| wb_data | output | 64 | Write-back value (valid with done) |

## Verification
The hardest cases to reach from the ports are the 32-bit operations whose inputs carry non-zero upper halves. A 32-bit compare-exchange must match when R0 differs from memory only in its upper half. A 32-bit add that carries out of bit 31 must leave the upper half of the word untouched. Directed requests build these cases on purpose. Random requests, for their part, copy the current memory word into R0 about half the time, so both arms of compare-exchange occur often. The bench's memory model counts reads and writes per request, which shows whether the mismatch and error paths really skip the write.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_OR   = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_XCHG = 3'd4,
    OP_CMPX = 3'd5
  } atom_op_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_SRC  = 2'd1,
    WB_R0   = 2'd2
  } wb_tgt_e;

  localparam logic [7:0] OPC_NARROW = 8'hc3;
  localparam logic [7:0] OPC_WIDE   = 8'hdb;

  typedef struct packed {
    atom_op_e op;
    logic     wide;
    logic     fetch;
    logic     bad;
  } atom_cmd_t;
endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_pkg::*;
(
  input  logic [7:0]  opcode,
  input  logic [31:0] imm,
  output atom_cmd_t   cmd
);
  logic bad_imm;

  always_comb begin
    cmd.wide  = (opcode == OPC_WIDE);
    cmd.fetch = imm[0];
    cmd.op    = OP_ADD;
    bad_imm   = 1'b0;
    unique case (imm)
      32'h00, 32'h01: cmd.op = OP_ADD;
      32'h40, 32'h41: cmd.op = OP_OR;
      32'h50, 32'h51: cmd.op = OP_AND;
      32'ha0, 32'ha1: cmd.op = OP_XOR;
      32'he1:         cmd.op = OP_XCHG;
      32'hf1:         cmd.op = OP_CMPX;
      default:        bad_imm = 1'b1;
    endcase
    cmd.bad = bad_imm || !((opcode == OPC_NARROW) || (opcode == OPC_WIDE));
  end
endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  atom_cmd_t          cmd,
  input  logic [DATA_W-1:0]  old_raw,
  input  logic [DATA_W-1:0]  src,
  input  logic [DATA_W-1:0]  r0,
  output logic [DATA_W-1:0]  new_val,
  output logic               wr_en,
  output wb_tgt_e            tgt,
  output logic [DATA_W-1:0]  wb_val
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] a, b, raw;
  logic              match;

  always_comb begin
    a = cmd.wide ? old_raw : {{HALF_W{1'b0}}, old_raw[HALF_W-1:0]};
    b = cmd.wide ? src     : {{HALF_W{1'b0}}, src[HALF_W-1:0]};
    unique case (cmd.op)
      OP_ADD:  raw = a + b;
      OP_OR:   raw = a | b;
      OP_AND:  raw = a & b;
      OP_XOR:  raw = a ^ b;
      default: raw = b;
    endcase
    new_val = cmd.wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    match   = cmd.wide ? (old_raw == r0) : (old_raw[HALF_W-1:0] == r0[HALF_W-1:0]);
    wr_en   = (cmd.op != OP_CMPX) || match;
    if (cmd.op == OP_CMPX)                         tgt = WB_R0;
    else if ((cmd.op == OP_XCHG) || cmd.fetch)     tgt = WB_SRC;
    else                                           tgt = WB_NONE;
    wb_val  = (tgt == WB_NONE) ? '0 : a;
  end
endmodule

// File: rtl/atom_ctrl.sv
module atom_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bad,
  output logic ready,
  output logic rd_phase,
  output logic mod_phase,
  output logic fin_phase
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_MOD, S_FIN} state_e;
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req_valid) state_d = bad ? S_FIN : S_RD;
      S_RD:   state_d = S_MOD;
      S_MOD:  state_d = S_FIN;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign ready     = (state_q == S_IDLE);
  assign rd_phase  = (state_q == S_RD);
  assign mod_phase = (state_q == S_MOD);
  assign fin_phase = (state_q == S_FIN);
endmodule

// File: rtl/atom_rmw_unit.sv
module atom_rmw_unit
  import atom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [31:0]       req_imm,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_dst,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] req_r0,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              lock,
  output logic              done,
  output logic              err,
  output logic [1:0]        wb_tgt,
  output logic [DATA_W-1:0] wb_data
);
  atom_cmd_t         cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q, eff_addr;
  logic [DATA_W-1:0] new_val, wb_val, wb_q;
  logic              wr_en, err_q, accept;
  logic              rd_phase, mod_phase, fin_phase;
  wb_tgt_e           tgt, tgt_q;

  atom_decode u_dec (.opcode(req_opcode), .imm(req_imm), .cmd(cmd_d));

  atom_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bad(cmd_d.bad),
    .ready(req_ready), .rd_phase(rd_phase), .mod_phase(mod_phase), .fin_phase(fin_phase)
  );

  atom_alu #(.DATA_W(DATA_W)) u_alu (
    .cmd(cmd_q), .old_raw(mem_rdata), .src(src_q), .r0(r0_q),
    .new_val(new_val), .wr_en(wr_en), .tgt(tgt), .wb_val(wb_val)
  );

  assign accept   = req_valid && req_ready;
  assign eff_addr = req_dst + {{(DATA_W-OFF_W){req_offset[OFF_W-1]}}, req_offset};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      err_q  <= 1'b0;
      tgt_q  <= WB_NONE;
      wb_q   <= '0;
    end else if (accept) begin
      cmd_q  <= cmd_d;
      addr_q <= eff_addr[ADDR_W-1:0];
      src_q  <= req_src;
      r0_q   <= req_r0;
      err_q  <= cmd_d.bad;
      tgt_q  <= WB_NONE;
      wb_q   <= '0;
    end else if (mod_phase) begin
      tgt_q  <= tgt;
      wb_q   <= wb_val;
    end
  end

  assign lock      = rd_phase || mod_phase;
  assign mem_we    = mod_phase && wr_en;
  assign mem_req   = rd_phase || mem_we;
  assign mem_wide  = cmd_q.wide;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_val;
  assign done      = fin_phase;
  assign err       = fin_phase && err_q;
  assign wb_tgt    = fin_phase ? tgt_q : WB_NONE;
  assign wb_data   = fin_phase ? wb_q : '0;
endmodule

// File: rtl/atom_rmw_chk.sv
module atom_rmw_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              lock,
  input logic              done,
  input logic              err,
  input logic [1:0]        wb_tgt
);
  // R10: memory is touched only under lock
  a_r10_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> lock);
  // R10: a write directly follows a read to the same address
  a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_req && !mem_we) && $stable(mem_addr)));
  // R10: lock begins with the read
  a_r10_lock_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (mem_req && !mem_we));
  // R2: no acceptance while busy
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !req_ready);
  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: errors return nothing
  a_r3_err_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (wb_tgt == 2'd0));
  // R4: an error completion follows no locked access
  a_r4_err_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(lock));
endmodule

bind atom_rmw_unit atom_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .lock(lock), .done(done),
  .err(err), .wb_tgt(wb_tgt)
);

// File: tb/tb_atom_rmw_unit.sv
module tb_atom_rmw_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = '0;
  logic [31:0] req_imm = '0;
  logic [15:0] req_offset = '0;
  logic [63:0] req_dst = '0, req_src = '0, req_r0 = '0;
  logic        mem_req, mem_we, mem_wide, lock, done, err;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0] mem_wdata, wb_data;
  logic [63:0] mem_rdata = '0;
  logic [1:0]  wb_tgt;

  int errors = 0;
  int checks = 0;
  logic [63:0] mem [16];
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] rd_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atom_rmw_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_imm(req_imm), .req_offset(req_offset),
    .req_dst(req_dst), .req_src(req_src), .req_r0(req_r0),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .lock(lock), .done(done),
    .err(err), .wb_tgt(wb_tgt), .wb_data(wb_data)
  );

  // Bench memory: 16 words selected by address bits [6:3]
  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr[6:3]];
      rd_cnt    <= rd_cnt + 1;
      rd_addr   <= mem_addr;
    end
    if (mem_req && mem_we) begin
      if (mem_wide) mem[mem_addr[6:3]] <= mem_wdata;
      else          mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
      wr_cnt <= wr_cnt + 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] opc, input logic [31:0] imm,
      input logic [63:0] word, input logic [63:0] src, input logic [63:0] r0,
      output logic bad, output logic wr, output logic [63:0] nword,
      output logic [1:0] tgt, output logic [63:0] wb);
    logic wide;
    logic [63:0] a, b, r;
    wide = (opc == 8'hdb);
    a = wide ? word : {32'h0, word[31:0]};
    b = wide ? src  : {32'h0, src[31:0]};
    bad = !((opc == 8'hc3) || (opc == 8'hdb));
    wr = 1'b1; tgt = 2'd0; r = b;
    case (imm)
      32'h00, 32'h01: r = a + b;
      32'h40, 32'h41: r = a | b;
      32'h50, 32'h51: r = a & b;
      32'ha0, 32'ha1: r = a ^ b;
      32'he1: r = b;
      32'hf1: begin
        r = b;
        wr = wide ? (word == r0) : (word[31:0] == r0[31:0]);
      end
      default: bad = 1'b1;
    endcase
    if (imm == 32'hf1) tgt = 2'd2;
    else if (imm[0]) tgt = 2'd1;
    if (bad) begin wr = 1'b0; tgt = 2'd0; end
    wb = (tgt == 2'd0) ? 64'h0 : a;
    nword = word;
    if (wr) begin
      if (wide) nword = r;
      else nword[31:0] = r[31:0];
    end
  endfunction

  task automatic run(input string tag, input logic [7:0] opc, input logic [31:0] imm,
      input logic [15:0] off, input logic [63:0] eff, input logic [63:0] src,
      input logic [63:0] r0);
    logic bad, wr;
    logic [63:0] nword, wb, dst;
    logic [1:0] tgt;
    int cyc;
    int idx;
    idx = int'(eff[6:3]);
    model(opc, imm, mem[idx], src, r0, bad, wr, nword, tgt, wb);
    dst = eff - {{48{off[15]}}, off};
    @(negedge clk);
    chk({tag, " R2 ready idle"}, 64'(req_ready), 64'h1);
    req_valid = 1'b1; req_opcode = opc; req_imm = imm; req_offset = off;
    req_dst = dst; req_src = src; req_r0 = r0;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0; req_opcode = $urandom; req_dst = {$urandom, $urandom};
    cyc = 1;
    if (!bad) begin
      chk({tag, " R2 busy"}, 64'(req_ready), 64'h0);
      chk({tag, " R10 locked read"}, {61'h0, lock, mem_req, mem_we}, 64'h6);
      chk({tag, " R3 width"}, 64'(mem_wide), 64'(opc == 8'hdb));
    end
    while (!done && cyc < 10) begin @(negedge clk); cyc = cyc + 1; end
    chk({tag, " R2 latency"}, 64'(cyc), bad ? 64'd1 : 64'd3);
    chk({tag, " R4 err"}, 64'(err), 64'(bad));
    chk({tag, " R7 R8 R9 target"}, 64'(wb_tgt), 64'(tgt));
    chk({tag, " R7 R8 R9 wb data"}, wb_data, wb);
    chk({tag, " R10 lock released"}, 64'(lock), 64'h0);
    chk({tag, " R11 reads"}, 64'(rd_cnt), bad ? 64'd0 : 64'd1);
    chk({tag, " R9 R11 writes"}, 64'(wr_cnt), 64'(wr));
    if (!bad) chk({tag, " R5 address"}, 64'(rd_addr), 64'(eff[ADDR_W-1:0]));
    chk({tag, " R6 memory"}, mem[idx], nword);
    @(negedge clk);
    chk({tag, " R11 pulse"}, 64'(done), 64'h0);
  endtask

  function automatic logic [31:0] pick_imm(input int k);
    case (k)
      0: return 32'h00; 1: return 32'h01; 2: return 32'h40; 3: return 32'h41;
      4: return 32'h50; 5: return 32'h51; 6: return 32'ha0; 7: return 32'ha1;
      8: return 32'he1; default: return 32'hf1;
    endcase
  endfunction

  initial begin
    logic [63:0] eff, r0, s;
    int idx;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(req_ready), 64'h1);
    chk("R1 idle", {61'h0, lock, mem_req, done}, 64'h0);
    rst_n = 1'b1;

    mem[2] = 64'hffff_ffff_ffff_fffe;
    run("R6 add64 wrap", 8'hdb, 32'h01, 16'h0010, 64'h0000_0000_0000_0210, 64'h3, 0);
    mem[3] = 64'h1234_5678_ffff_ffff;
    run("R6 add32 carry", 8'hc3, 32'h01, 16'hfff8, 64'h1111_0000_0000_0218, 64'hdead_0000_0000_0002, 0);
    mem[4] = 64'haaaa_bbbb_0000_0005;
    run("R9 cmpx32 match", 8'hc3, 32'hf1, 16'h0, 64'h220, 64'h7777_7777_1234_5678, 64'hffff_ffff_0000_0005);
    mem[5] = 64'h0000_0001_0000_0005;
    run("R9 cmpx64 miss", 8'hdb, 32'hf1, 16'h4, 64'h228, 64'h99, 64'h5);
    run("R9 cmpx64 match", 8'hdb, 32'hf1, 16'h4, 64'h228, 64'h99, 64'h0000_0001_0000_0005);
    run("R8 xchg64", 8'hdb, 32'he1, 16'h8000, 64'h230, 64'hcafe_f00d_0000_0001, 0);
    run("R7 and nofetch", 8'hdb, 32'h50, 16'h0, 64'h238, 64'hf0f0_f0f0_f0f0_f0f0, 0);
    run("R3 bad opcode", 8'h7b, 32'h00, 16'h0, 64'h240, 64'h1, 0);
    run("R3 bad width", 8'hd3, 32'h01, 16'h0, 64'h240, 64'h1, 0);
    run("R4 bad imm e0", 8'hdb, 32'he0, 16'h0, 64'h248, 64'h1, 0);
    run("R4 bad imm f0", 8'hc3, 32'hf0, 16'h0, 64'h248, 64'h1, 0);
    run("R4 bad imm 02", 8'hc3, 32'h02, 16'h0, 64'h248, 64'h1, 0);

    for (int n = 0; n < 200; n++) begin
      idx = $urandom_range(15);
      eff = {$urandom, 16'($urandom), 16'h0200 | 16'(idx << 3)};
      s = {$urandom, $urandom};
      r0 = ($urandom_range(1) == 1) ? mem[idx] : {$urandom, $urandom};
      if ($urandom_range(1) == 1) r0[63:32] = $urandom;
      run("R6 random", ($urandom_range(1) == 1) ? 8'hdb : 8'hc3,
          pick_imm($urandom_range(9)), 16'($urandom), eff, s, r0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule